// File: doc/BRIEF.md
# Regulator Fault Persistence Filter and Protection Latch

This block sits between the analog fault comparators of a multi-rail power manager and its rail start-up sequencer. It receives digital flags that say a switching rail has sagged to half its target or less, that the die is over temperature, or that the internal control supply has collapsed. It decides whether the sequencer has to power everything down, and whether that power-down has to stay in place.

Rail-sag and over-temperature flags pass through a persistence filter. A flag has to stay high without a single low sample for a programmable window before protection engages. Once protection engages, the block asks the sequencer to shut every rail, the external gate control and the linear rail. After a second window the block latches. Removing the fault does not undo the latch. Only dropping and reapplying the enable, or a fresh release of the undervoltage lockout, re-arms the block, and it then sends a restart pulse to the sequencer.

A collapse of the internal supply is handled on its own path. It stops everything on the next clock without latching, and the start sequence runs again as soon as the collapse clears. A rail's sag flag is masked while the sequencer reports that rail as off or still ramping. The block has no reset-pin output, so protection never pulls the system reset low. All outputs are registered.

Top module: `fault_guard`

## Requirements
- R1: While `rst` is high and on the first sample after it, `shutdown_req` is 1 and both `fault_latched` and `restart_pulse` are 0.
- R2: The block is armed when `enable` and `uvlo_ok` are both 1. On the first edge at which it is armed (from idle, with `vsup_short` low), `restart_pulse` is 1 and `shutdown_req` is 0 on the following cycle.
- R3: A qualified fault flag that is sampled high on FILT_CYC consecutive edges, or fewer, never causes a shutdown. A single low sample restarts the count. If the flag is sampled high on FILT_CYC+1 consecutive edges while running, `shutdown_req` rises after edge FILT_CYC+2.
- R4: Bit i of `rail_short` is ignored while bit i of `rail_active` is 0, for any duration.
- R5: When protection engages, `shutdown_req` goes to 1. `fault_latched` rises exactly LATCH_CYC edges later, and both stay 1 while the block remains armed.
- R6: Once protection has engaged, clearing every fault flag neither releases `shutdown_req` nor produces `restart_pulse`. Dropping `enable` or `uvlo_ok` for one edge clears `fault_latched`, and re-arming then gives a restart as in R2.
- R7: If `vsup_short` is 1 while armed and running, `shutdown_req` is 1 from the next cycle and `fault_latched` stays 0. On the first edge with `vsup_short` low again, `restart_pulse` is issued and `shutdown_req` drops.
- R8: `over_temp` is filtered and engages protection exactly as a rail flag does.
- R9: `restart_pulse` is never high on two consecutive cycles, and it is only high on a cycle after an edge at which the block was armed.
- R10: Losing the armed condition has priority over every fault. It returns the block to idle with `shutdown_req` set to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Enable request, already synchronized |
| uvlo_ok | input | 1 | 1 when the input supply is above the lockout threshold |
| rail_short | input | NRAIL | Per switching rail: output at or below half its target |
| rail_active | input | NRAIL | Per rail: enabled and past soft-start (sag flag qualifier) |
| over_temp | input | 1 | Die over-temperature flag |
| vsup_short | input | 1 | Internal control supply shorted |
| shutdown_req | output | 1 | Sequencer must hold all rails off |
| fault_latched | output | 1 | Protection latch set |
| restart_pulse | output | 1 | One-cycle request to run the start sequence |

## Verification
The filter is driven with runs of exactly FILT_CYC and FILT_CYC+1 high samples, with two near-full runs joined by a single low sample, and with a permanently high flag on a rail whose qualifier is low. These patterns separate a filter that counts from one that only accumulates, and expose a boundary that is off by one. Latch behaviour is tried by removing the fault after the trip and then re-arming through `enable` and through `uvlo_ok`. The supply-collapse path is exercised by contrasting its automatic restart with the latched path. A long seeded random phase then mixes flags, qualifiers, lockout drops and supply collapses, and compares every output each cycle with a reference model written in the bench from the requirements.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_HOLD = 3'd2,
    ST_TRIP = 3'd3,
    ST_LOCK = 3'd4
  } fg_state_t;
endpackage

// File: rtl/fg_persist.sv
module fg_persist #(
  parameter int CYC = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic flag,
  output logic hit
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(CYC);

  logic [CW-1:0] cnt;

  // cnt holds the number of earlier consecutive high samples, saturating at LIM
  always_ff @(posedge clk) begin
    if (rst || clr || !flag) begin
      cnt <= '0;
      hit <= 1'b0;
    end else begin
      if (cnt != LIM) cnt <= cnt + 1'b1;
      hit <= (cnt == LIM);
    end
  end

  // R3: a hit needs the flag, unmasked, on the previous edge
  a_r3_hit_needs_flag: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(flag && !clr));

  // R3: a hit can only begin while the flag is still high
  a_r3_hit_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(hit) |-> $past(flag));
endmodule

// File: rtl/fg_ctrl.sv
module fg_ctrl
  import fg_pkg::*;
#(
  parameter int LATCH_CYC = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic vsup,
  input  logic trip,
  output logic running,
  output logic shutdown_req,
  output logic fault_latched,
  output logic restart_pulse
);
  localparam int TW = $clog2(LATCH_CYC + 1);
  localparam logic [TW-1:0] TLAST = TW'(LATCH_CYC - 1);

  fg_state_t st_q, st_d;
  logic [TW-1:0] tmr;

  always_comb begin
    st_d = st_q;
    if (!armed) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: st_d = vsup ? ST_HOLD : ST_RUN;
        ST_RUN:  st_d = vsup ? ST_HOLD : (trip ? ST_TRIP : ST_RUN);
        ST_HOLD: st_d = vsup ? ST_HOLD : ST_RUN;
        ST_TRIP: st_d = (tmr == TLAST) ? ST_LOCK : ST_TRIP;
        ST_LOCK: st_d = ST_LOCK;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      tmr           <= '0;
      shutdown_req  <= 1'b1;
      fault_latched <= 1'b0;
      restart_pulse <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_d == ST_TRIP && st_q != ST_TRIP) tmr <= '0;
      else if (st_q == ST_TRIP)               tmr <= tmr + 1'b1;
      shutdown_req  <= (st_d != ST_RUN);
      fault_latched <= (st_d == ST_LOCK);
      restart_pulse <= (st_d == ST_RUN) && (st_q != ST_RUN);
    end
  end

  assign running = (st_q == ST_RUN);

  // R5: the latch never coexists with running rails
  a_r5_latch_holds_off: assert property (@(posedge clk) disable iff (rst)
    fault_latched |-> shutdown_req);

  // R6: while still armed the latch cannot clear
  a_r6_latch_sticky: assert property (@(posedge clk) disable iff (rst)
    (fault_latched && armed) |=> fault_latched);

  // R7: a supply collapse stops everything on the next cycle
  a_r7_vsup_stop: assert property (@(posedge clk) disable iff (rst)
    vsup |=> shutdown_req);

  // R9: restart is a single-cycle pulse
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    restart_pulse |=> !restart_pulse);

  // R9: restart only follows an armed edge
  a_r9_armed_restart: assert property (@(posedge clk) disable iff (rst)
    restart_pulse |-> $past(armed));

  // R10: losing the armed condition forces shutdown without a latch
  a_r10_disarm: assert property (@(posedge clk) disable iff (rst)
    !armed |=> (shutdown_req && !fault_latched));
endmodule

// File: rtl/fault_guard.sv
module fault_guard #(
  parameter int NRAIL     = 2,
  parameter int FILT_CYC  = 250000,
  parameter int LATCH_CYC = 250000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             uvlo_ok,
  input  logic [NRAIL-1:0] rail_short,
  input  logic [NRAIL-1:0] rail_active,
  input  logic             over_temp,
  input  logic             vsup_short,
  output logic             shutdown_req,
  output logic             fault_latched,
  output logic             restart_pulse
);
  localparam int NSRC = NRAIL + 1;

  logic            armed;
  logic            running;
  logic [NSRC-1:0] qual;
  logic [NSRC-1:0] hits;

  assign armed = enable & uvlo_ok;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      if (g < NRAIL) begin : g_rail
        assign qual[g] = rail_short[g] & rail_active[g];
      end else begin : g_temp
        assign qual[g] = over_temp;
      end
      fg_persist #(.CYC(FILT_CYC)) i_filt (
        .clk  (clk),
        .rst  (rst),
        .clr  (!running),
        .flag (qual[g]),
        .hit  (hits[g])
      );
    end
  endgenerate

  fg_ctrl #(.LATCH_CYC(LATCH_CYC)) i_ctrl (
    .clk           (clk),
    .rst           (rst),
    .armed         (armed),
    .vsup          (vsup_short),
    .trip          (|hits),
    .running       (running),
    .shutdown_req  (shutdown_req),
    .fault_latched (fault_latched),
    .restart_pulse (restart_pulse)
  );

  // R4: a masked rail flag never reaches the filters
  a_r4_mask: assert property (@(posedge clk) disable iff (rst)
    !rail_active[0] |-> !qual[0]);
endmodule

// File: tb/test_fault_guard.sv
module test_fault_guard;
  localparam int NR = 2;
  localparam int F  = 12;
  localparam int L  = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0, uvlo_ok = 1'b0, over_temp = 1'b0, vsup_short = 1'b0;
  logic [NR-1:0] rail_short = '0, rail_active = '0;
  logic shutdown_req, fault_latched, restart_pulse;

  always #2 clk = ~clk;

  fault_guard #(.NRAIL(NR), .FILT_CYC(F), .LATCH_CYC(L)) i_fault_guard (
    .clk(clk), .rst(rst), .enable(enable), .uvlo_ok(uvlo_ok),
    .rail_short(rail_short), .rail_active(rail_active),
    .over_temp(over_temp), .vsup_short(vsup_short),
    .shutdown_req(shutdown_req), .fault_latched(fault_latched),
    .restart_pulse(restart_pulse)
  );

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  // reference model: 0 idle, 1 run, 2 hold, 3 trip, 4 locked
  int m_st = 0, m_t = 0;
  int m_cnt [NR+1];
  bit m_hit [NR+1];
  bit e_sd = 1, e_fl = 0, e_rs = 0;

  function automatic int next_state(int st, bit arm, bit vs, bit anyhit, int t);
    if (!arm) return 0;
    case (st)
      0: return vs ? 2 : 1;
      1: return vs ? 2 : (anyhit ? 3 : 1);
      2: return vs ? 2 : 1;
      3: return (t == L - 1) ? 4 : 3;
      default: return 4;
    endcase
  endfunction

  task automatic model_edge();
    bit anyhit = 0;
    int nx;
    bit fl [NR+1];
    for (int i = 0; i < NR; i++) fl[i] = rail_short[i] & rail_active[i];
    fl[NR] = over_temp;
    if (rst) begin
      m_st = 0; m_t = 0; e_sd = 1; e_fl = 0; e_rs = 0;
      for (int i = 0; i <= NR; i++) begin m_cnt[i] = 0; m_hit[i] = 0; end
      return;
    end
    for (int i = 0; i <= NR; i++) anyhit |= m_hit[i];
    nx = next_state(m_st, enable & uvlo_ok, vsup_short, anyhit, m_t);
    for (int i = 0; i <= NR; i++) begin
      if (m_st != 1 || !fl[i]) begin m_cnt[i] = 0; m_hit[i] = 0; end
      else begin
        m_hit[i] = (m_cnt[i] >= F);
        if (m_cnt[i] < F) m_cnt[i]++;
      end
    end
    if (nx == 3 && m_st != 3) m_t = 0;
    else if (m_st == 3) m_t++;
    e_sd = (nx != 1);
    e_fl = (nx == 4);
    e_rs = (nx == 1) && (m_st != 1);
    m_st = nx;
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk("R3/R5/R7 model", "shutdown_req", shutdown_req, e_sd);
      chk("R5/R6 model", "fault_latched", fault_latched, e_fl);
      chk("R2/R9 model", "restart_pulse", restart_pulse, e_rs);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    tick(3);
    // R1 reset state
    chk("R1", "shutdown_req", shutdown_req, 1'b1);
    chk("R1", "fault_latched", fault_latched, 1'b0);
    chk("R1", "restart_pulse", restart_pulse, 1'b0);
    rst = 1'b0;
    tick(2);
    chk("R1", "shutdown_req idle", shutdown_req, 1'b1);

    // R2 arming
    enable = 1; uvlo_ok = 1; rail_active = '1;
    tick();
    chk("R2", "restart_pulse", restart_pulse, 1'b1);
    chk("R2", "shutdown_req", shutdown_req, 1'b0);
    tick();
    chk("R9", "restart_pulse width", restart_pulse, 1'b0);

    // R3 run of exactly F samples is tolerated
    rail_short[0] = 1; tick(F); rail_short[0] = 0; tick(4);
    chk("R3", "F-sample run", shutdown_req, 1'b0);
    // R3 two near-full runs split by one low sample
    rail_short[1] = 1; tick(F); rail_short[1] = 0; tick(1);
    rail_short[1] = 1; tick(F); rail_short[1] = 0; tick(4);
    chk("R3", "split run", shutdown_req, 1'b0);

    // R4 masked rail flag held long
    rail_active[1] = 0; rail_short[1] = 1; tick(3 * F);
    chk("R4", "masked rail", shutdown_req, 1'b0);
    rail_short[1] = 0; rail_active[1] = 1; tick(2);

    // R3/R5 trip on F+1 samples
    rail_short[0] = 1; tick(F + 1);
    chk("R3", "one edge before trip", shutdown_req, 1'b0);
    tick();
    chk("R5", "shutdown on trip", shutdown_req, 1'b1);
    rail_short[0] = 0;
    tick(L - 1);
    chk("R5", "latch not yet", fault_latched, 1'b0);
    tick();
    chk("R5", "latch set", fault_latched, 1'b1);
    tick(20);
    chk("R6", "fault removed, still off", shutdown_req, 1'b1);
    chk("R6", "still latched", fault_latched, 1'b1);
    // R6 re-arm through enable
    enable = 0; tick();
    chk("R6", "latch cleared", fault_latched, 1'b0);
    chk("R10", "disarmed shutdown", shutdown_req, 1'b1);
    enable = 1; tick();
    chk("R6", "restart after re-arm", restart_pulse, 1'b1);
    chk("R6", "running after re-arm", shutdown_req, 1'b0);

    // R7 supply collapse
    vsup_short = 1; tick();
    chk("R7", "immediate stop", shutdown_req, 1'b1);
    tick(3 * L);
    chk("R7", "no latch", fault_latched, 1'b0);
    vsup_short = 0; tick();
    chk("R7", "auto restart", restart_pulse, 1'b1);
    chk("R7", "running", shutdown_req, 1'b0);

    // R8 over temperature, then re-arm via lockout
    over_temp = 1; tick(F + 2);
    chk("R8", "thermal trip", shutdown_req, 1'b1);
    over_temp = 0; tick(L + 2);
    chk("R8", "thermal latch", fault_latched, 1'b1);
    uvlo_ok = 0; tick(); uvlo_ok = 1; tick();
    chk("R6", "lockout re-arm restart", restart_pulse, 1'b1);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 29) == 0) rail_short[0] = ~rail_short[0];
      if ($urandom_range(0, 29) == 0) rail_short[1] = ~rail_short[1];
      if ($urandom_range(0, 59) == 0) over_temp = ~over_temp;
      if ($urandom_range(0, 19) == 0) rail_active = NR'($urandom_range(0, 3));
      if ($urandom_range(0, 99) == 0) vsup_short = ~vsup_short;
      enable  = ($urandom_range(0, 199) != 0);
      uvlo_ok = ($urandom_range(0, 249) != 0);
      tick();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule